// File: doc/BRIEF.md
# Programmable UART Baud Tick Generator

This block turns a fast system clock into the 16x oversampling tick that drives a UART's transmit and receive engines. A 16-bit divisor, held as a low byte and a high byte, sets the tick rate to the system clock rate divided by the divisor. Each tick is a single-cycle enable pulse, not a clock, so the engines downstream stay in the system clock domain.

Software programs the divisor through a plain register write port. A write lands in the divisor only while the divisor-access enable is high. A write can target one byte, chosen by a byte select, or both bytes at once as a single 16-bit word. Any accepted write reloads the down-counter at once. A new rate therefore starts cleanly and does not wait out the rest of a long old count. A divisor of zero silences the tick. The stored bytes can be read back through the same byte select.

The register port is a control interface. A write takes effect on the clock edge that samples it and cannot be held off, so the port has no valid/ready handshake and no back-pressure. The tick is a free-running strobe and is not held off either. A consumer that misses a tick does not delay the next one.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset both divisor bytes read back as zero and `tick_16x` stays low until a nonzero divisor is written.
- R2: With a nonzero divisor D held steady, `tick_16x` is high for exactly one clock out of every D clocks.
- R3: With a divisor of 1, `tick_16x` is high on every clock.
- R4: A write with `wr_wide` high loads the low byte from `wr_data[7:0]` and the high byte from `wr_data[15:8]` in the same edge.
- R5: A write with `wr_wide` low loads only the byte named by `wr_sel` (0 = low byte, 1 = high byte) from `wr_data[7:0]` and leaves the other byte unchanged.
- R6: `rd_data` shows the low divisor byte when `rd_sel` is 0 and the high byte when `rd_sel` is 1, with no clock delay.
- R7: Any accepted write restarts the count from the new divisor D. `tick_16x` stays low in the cycle after the write edge. The first tick appears exactly D clocks after the write edge, and the count in progress is dropped.
- R8: When the combined divisor is zero, `tick_16x` stays low for as long as the divisor stays zero.
- R9: A write strobe presented while `div_access` is low changes neither divisor byte nor the tick timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_access | input | 1 | Routes register writes to the divisor bytes when high |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_wide | input | 1 | 1 = write both bytes from a 16-bit word, 0 = write one byte |
| wr_sel | input | 1 | Byte select for byte writes: 0 low, 1 high |
| wr_data | input | 16 | Write data; byte writes use bits 7:0 |
| rd_sel | input | 1 | Byte select for readback: 0 low, 1 high |
| rd_data | output | 8 | Selected divisor byte |
| tick_16x | output | 1 | Single-cycle oversampling tick |

## Verification
A table of divisors is walked with word writes: 1 and 2, small odd and even values, 16, and values at and just past the 255/256 byte boundary. Each entry checks the quiet write cycle, the first-tick distance and one further period. Together they separate an off-by-one in the reload from a correct count and show whether the high byte feeds the counter. Directed sequences then cover reset, byte writes to each byte with readback, writes blocked by the access enable, a write in the middle of a 1000-clock count, and a zero divisor. These show that a reload drops the old count, that a blocked write is ignored, and that zero holds the tick low rather than wrapping.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned DIV_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NBYTES = DIV_W / BYTE_W;
  localparam int unsigned SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  typedef logic [DIV_W-1:0]  div_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [SEL_W-1:0]  sel_t;
endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs
  import baud_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_ok,
  input  logic  wr_all,
  input  sel_t  wr_sel,
  input  div_t  wr_data,
  input  sel_t  rd_sel,
  output byte_t rd_data,
  output div_t  div_q,
  output div_t  div_nxt,
  output logic  load
);
  div_t lat_q;

  // Next divisor: each byte lane takes new data when addressed.
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic hit;
    assign hit = wr_ok && (wr_all || (wr_sel == sel_t'(b)));
    assign div_nxt[b*BYTE_W +: BYTE_W] =
      !hit   ? lat_q[b*BYTE_W +: BYTE_W] :
      wr_all ? wr_data[b*BYTE_W +: BYTE_W] :
               wr_data[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     lat_q <= '0;
    else if (wr_ok) lat_q <= div_nxt;
  end

  assign load    = wr_ok;
  assign div_q   = lat_q;
  assign rd_data = lat_q[rd_sel*BYTE_W +: BYTE_W];

  // R9: divisor only moves on an accepted write
  a_r9_hold_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> $stable(lat_q));
  // R5: a byte write leaves the other byte lane untouched
  a_r5_other_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !wr_all && wr_sel == sel_t'(0)) |=>
      (lat_q[DIV_W-1:BYTE_W] == $past(lat_q[DIV_W-1:BYTE_W])));
endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter
  import baud_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  div_t load_val,
  input  div_t div,
  output logic tick
);
  div_t cnt_q;
  logic tick_q;
  logic run;

  assign run = (div != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_val;
      tick_q <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q <= div_t'(1)) begin
      cnt_q  <= div;
      tick_q <= (cnt_q == div_t'(1));
    end else begin
      cnt_q  <= cnt_q - div_t'(1);
      tick_q <= 1'b0;
    end
  end

  assign tick = tick_q;

  // R7: no tick in the cycle after a reload
  a_r7_quiet_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !tick_q);
  // R8: a zero divisor never produces a tick
  a_r8_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '0) |-> !tick_q);
  // R2: ticks are single-cycle for divisors above one
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && div > div_t'(1) && !load) |=> !tick_q);
  // R3: divisor one fires every clock once running
  a_r3_every_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (div == div_t'(1) && cnt_q == div_t'(1) && !load) |=> tick_q);
  // R2: the count never exceeds the divisor
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q <= div));
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import baud_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        div_access,
  input  logic        wr_en,
  input  logic        wr_wide,
  input  logic        wr_sel,
  input  logic [15:0] wr_data,
  input  logic        rd_sel,
  output logic [7:0]  rd_data,
  output logic        tick_16x
);
  div_t div_q, div_nxt;
  logic load;
  logic wr_ok;

  assign wr_ok = wr_en && div_access;

  baud_div_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ok   (wr_ok),
    .wr_all  (wr_wide),
    .wr_sel  (sel_t'(wr_sel)),
    .wr_data (wr_data),
    .rd_sel  (sel_t'(rd_sel)),
    .rd_data (rd_data),
    .div_q   (div_q),
    .div_nxt (div_nxt),
    .load    (load)
  );

  baud_div_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (div_nxt),
    .div      (div_q),
    .tick     (tick_16x)
  );

  // R4: word write lands both bytes on the same edge
  a_r4_word_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wr_wide) |=> (div_q == $past(wr_data)));
  // R1: readback stays zero until something is written
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |=> (div_q == '0 && !tick_16x));
endmodule

// File: tb/sim_uart_baud_gen.sv
module sim_uart_baud_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        div_access = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_wide = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [7:0]  rd_data;
  logic        tick_16x;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  uart_baud_gen u0 (.*);

  localparam int NV = 8;
  localparam int unsigned VEC [NV] = '{1, 2, 3, 7, 16, 255, 256, 300};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit acc, input bit wide, input bit sel, input logic [15:0] d);
    @(negedge clk);
    div_access = acc; wr_en = 1'b1; wr_wide = wide; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; div_access = 1'b0;
  endtask

  // Called right after a write's edge: checks quiet write cycle then n periods of d
  task automatic expect_periods(input int d, input int n, input string req);
    int bad = 0;
    int first_bad = -1;
    if (tick_16x !== 1'b0) begin bad++; first_bad = 0; end
    for (int p = 0; p < n; p++) begin
      for (int k = 1; k <= d; k++) begin
        @(negedge clk);
        if (tick_16x !== (k == d)) begin
          bad++;
          if (first_bad < 0) first_bad = p * d + k;
        end
      end
    end
    check(bad == 0, req, first_bad, -1);
  endtask

  task automatic expect_quiet(input int cycles, input string req);
    int hits = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (tick_16x !== 1'b0) hits++;
    end
    check(hits == 0, req, hits, 0);
  endtask

  task automatic rb(input bit sel, input int exp, input string req);
    @(negedge clk);
    rd_sel = sel;
    #1;
    check(rd_data == exp[7:0], req, rd_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rb(1'b0, 0, "R1 low byte after reset");
    rb(1'b1, 0, "R1 high byte after reset");
    expect_quiet(40, "R1 no tick after reset");

    // Vector table walk: R2, R3, R4, R7
    for (int i = 0; i < NV; i++) begin
      wr(1'b1, 1'b1, 1'b0, VEC[i][15:0]);
      expect_periods(VEC[i], 2, (VEC[i] == 1) ? "R3 divisor one" : "R2/R7 period after word write");
      rb(1'b0, VEC[i] & 255, "R4 low byte of word");
      rb(1'b1, VEC[i] >> 8, "R4 high byte of word");
    end

    // R5/R6 byte writes
    wr(1'b1, 1'b1, 1'b0, 16'h0000);
    wr(1'b1, 1'b0, 1'b1, 16'hAB01);  // high byte = 0x01 -> divisor 256
    rb(1'b1, 1, "R5 high byte written");
    rb(1'b0, 0, "R5 low byte kept");
    wr(1'b1, 1'b0, 1'b0, 16'h1205);  // low byte = 0x05 -> divisor 261
    rb(1'b0, 5, "R6 low byte readback");
    rb(1'b1, 1, "R5 high byte kept");
    wr(1'b1, 1'b0, 1'b1, 16'h0000);  // high = 0 -> divisor 5
    expect_periods(5, 3, "R7 byte write reloads");

    // R9 blocked write
    wr(1'b0, 1'b1, 1'b0, 16'h0003);
    rb(1'b0, 5, "R9 low byte unchanged");
    rb(1'b1, 0, "R9 high byte unchanged");
    wr(1'b1, 1'b1, 1'b0, 16'd6);
    repeat (2) @(negedge clk);
    begin
      int since;
      since = 2;
      wr(1'b0, 1'b1, 1'b0, 16'd2);  // blocked; tick timing unchanged
      since = since + 2;            // two more edges elapsed
      // next tick must land at edge 6 after the accepted write
      expect_quiet(6 - since - 1, "R9 no early tick");
      @(negedge clk);
      check(tick_16x === 1'b1, "R9 timing unchanged", tick_16x, 1);
    end

    // R7 mid-count reload
    wr(1'b1, 1'b1, 1'b0, 16'd1000);
    repeat (10) @(negedge clk);
    wr(1'b1, 1'b1, 1'b0, 16'd4);
    expect_periods(4, 2, "R7 mid-count reload");

    // R8 zero stops
    wr(1'b1, 1'b1, 1'b0, 16'd0);
    expect_quiet(200, "R8 zero divisor silent");
    wr(1'b1, 1'b0, 1'b0, 16'd3);
    expect_periods(3, 2, "R8 restart from zero");

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rb(1'b0, 0, "R1 low byte after second reset");
    expect_quiet(20, "R1 quiet after second reset");

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule